// File: doc/BRIEF.md
# Burst Bus Target with Local Word Store

This block is the responding side of a burst bus in which address and data share one set of lines. A frame opens with an address phase that carries a byte address and a 4-bit command. Data phases follow, one word per handshake, and later words use consecutive addresses with no new address phase. The block holds a 16-word memory. It claims frames whose command is a memory read or memory write and whose address falls inside a parameterised window. It answers reads from the memory and commits writes into it, one byte lane at a time.

The shared lines are split into an input bus (`ad_in`), an output bus (`ad_out`) and a drive-enable (`ad_oe`). All bus control lines are active low. The initiator paces beats with `irdy_n`. The block paces them with `trdy_n` and announces that it has claimed the frame with `devsel_n`.

Control is a five-state machine:
- `ST_IDLE`: waiting for an address phase.
- `ST_SKIP`: a foreign or unsupported frame is in progress.
- `ST_RFETCH`: claimed read, first word being fetched.
- `ST_RDATA`: read data phases.
- `ST_WDATA`: write data phases.

Transitions:
- *claim-read*: `ST_IDLE`→`ST_RFETCH`
- *claim-write*: `ST_IDLE`→`ST_WDATA`
- *decline*: `ST_IDLE`→`ST_SKIP`
- *bus-free*: `ST_SKIP`→`ST_IDLE`
- *fetched*: `ST_RFETCH`→`ST_RDATA`
- *read-done*: `ST_RDATA`→`ST_IDLE`, on the final beat
- *write-done*: `ST_WDATA`→`ST_IDLE`, on the final beat

Top module: `burst_target`

## Requirements
- R1: After reset, `devsel_n` and `trdy_n` are high, `ad_oe` is low, and every memory word reads as zero.
- R2: In an address phase (`frame_n` low while idle), only `cbe_n` = 4'b0110 (memory read) or 4'b0111 (memory write) can claim the frame. Every other code is ignored, including 4'b0010 and 4'b0011 (device read/write): `devsel_n` stays high for the whole frame.
- R3: A frame is claimed only if its address A satisfies BASE <= A < BASE + 4*DEPTH (defaults BASE = 0x1000, DEPTH = 16). The starting word index is bits [5:2] of (A - BASE), and bits [1:0] are ignored.
- R4: `devsel_n` goes low in the cycle after a claimed address phase. For a write, `trdy_n` goes low in that same cycle.
- R5: For a claimed read, `ad_oe` is high from the cycle after the address phase, and `trdy_n` goes low one cycle later than `devsel_n`. Whenever `trdy_n` is low in a read, `ad_out` carries the memory word at the current word index.
- R6: A beat completes only on a clock edge where `irdy_n` and `trdy_n` are both low. A cycle with `irdy_n` high moves no data and leaves the word index unchanged.
- R7: The word index advances by one after each completed beat and wraps from 15 to 0.
- R8: On a write beat, `ad_in` byte lane b (bits 8b+7:8b) is stored only when `cbe_n[b]` is 0. The other bytes of the word keep their value.
- R9: The beat completed with `frame_n` high ends the frame. `devsel_n`, `trdy_n` and `ad_oe` are released in the next cycle, and a new address phase is accepted in the cycle after that.
- R10: After an ignored frame, the block stays silent until `frame_n` and `irdy_n` are both high. An ignored write leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame active (low); high on the final beat |
| irdy_n | input | 1 | Initiator ready (low) |
| cbe_n | input | 4 | Command in the address phase; active-low byte enables in write data phases |
| ad_in | input | 32 | Address in the address phase; write data in data phases |
| ad_out | output | 32 | Read data |
| ad_oe | output | 1 | High while the block drives read data |
| devsel_n | output | 1 | Frame claimed (low) |
| trdy_n | output | 1 | Target ready (low) |

## Verification
The final beat of a frame completes a data transfer and ends the frame in the same edge. It also advances the word index, and the word index can wrap in that same cycle. The bench provokes this with single-word frames and with bursts that start at word 14 and cross the wrap boundary. It then opens the next frame at once, and checks both the release timing and the memory contents that follow. Initiator stalls are also placed on the last beat of read and write bursts, to show that a stalled cycle neither moves data nor ends the frame. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_RFETCH,
        ST_RDATA,
        ST_WDATA
    } tgt_state_t;

endpackage

// File: rtl/burst_decode.sv
module burst_decode
    import burst_pkg::*;
#(
    parameter int              AW    = 32,
    parameter int              DEPTH = 16,
    parameter logic [AW-1:0]   BASE  = 32'h0000_1000,
    localparam int             IW    = $clog2(DEPTH),
    localparam int             WIN   = DEPTH * 4
) (
    input  logic [AW-1:0] ad_in,
    input  logic [3:0]    cmd,
    output logic          hit,
    output logic          is_read,
    output logic [IW-1:0] word_idx
);

    logic [AW-1:0] offset;
    logic          in_win;
    logic          cmd_ok;

    always_comb begin
        offset   = ad_in - BASE;
        in_win   = (ad_in >= BASE) && (offset < AW'(WIN));
        is_read  = (cmd == CMD_MEM_RD);
        cmd_ok   = is_read || (cmd == CMD_MEM_WR);
        hit      = in_win && cmd_ok;
        word_idx = offset[IW+1:2];
    end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] load_idx,
    input  logic          step,
    output logic [IW-1:0] ptr,
    output logic [IW-1:0] ptr_nxt
);

    always_comb begin
        if (load)      ptr_nxt = load_idx;
        else if (step) ptr_nxt = ptr + 1'b1;
        else           ptr_nxt = ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    // R7
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr == IW'($past(ptr) + 1'b1)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(ptr));

endmodule

// File: rtl/burst_mem.sv
module burst_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [NB-1:0] be,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [7:0] cells [DEPTH];
        logic [7:0] rd_lane;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
                rd_lane <= '0;
            end else begin
                if (we && be[b]) cells[waddr] <= wdata[8*b +: 8];
                rd_lane <= cells[raddr];
            end
        end

        assign rdata[8*b +: 8] = rd_lane;
    end

endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic hit,
    input  logic is_read,
    output logic devsel_n,
    output logic trdy_n,
    output logic ad_oe,
    output logic load,
    output logic step,
    output logic we
);

    tgt_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!frame_n) begin
                    if (!hit)         state_nxt = ST_SKIP;
                    else if (is_read) state_nxt = ST_RFETCH;
                    else              state_nxt = ST_WDATA;
                end
            end
            ST_SKIP:   if (frame_n && irdy_n) state_nxt = ST_IDLE;
            ST_RFETCH: state_nxt = ST_RDATA;
            ST_RDATA:  if (!irdy_n && frame_n) state_nxt = ST_IDLE;
            ST_WDATA:  if (!irdy_n && frame_n) state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        ad_oe    = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        we       = 1'b0;
        unique case (state)
            ST_IDLE:   load = !frame_n && hit;
            ST_SKIP:   ;
            ST_RFETCH: begin
                devsel_n = 1'b0;
                ad_oe    = 1'b1;
            end
            ST_RDATA: begin
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                ad_oe    = 1'b1;
                step     = !irdy_n;
            end
            ST_WDATA: begin
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                step     = !irdy_n;
                we       = !irdy_n;
            end
            default: ;
        endcase
    end

    // R4
    claim_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !frame_n && hit) |=> !devsel_n);

    // R2
    decline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !frame_n && !hit) |=> devsel_n);

    // R5
    read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !frame_n && hit && is_read) |=> (trdy_n && ad_oe));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe));

endmodule

// File: rtl/burst_target.sv
module burst_target #(
    parameter int            AW    = 32,
    parameter int            DEPTH = 16,
    parameter logic [31:0]   BASE  = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n,
    output logic        trdy_n
);

    localparam int IW = $clog2(DEPTH);
    localparam int NB = AW / 8;

    logic          hit, is_read;
    logic [IW-1:0] start_idx, ptr, ptr_nxt;
    logic          load, step, we;

    burst_decode #(.AW(AW), .DEPTH(DEPTH), .BASE(BASE)) u_dec (
        .ad_in    (ad_in),
        .cmd      (cbe_n),
        .hit      (hit),
        .is_read  (is_read),
        .word_idx (start_idx)
    );

    burst_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .hit      (hit),
        .is_read  (is_read),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .ad_oe    (ad_oe),
        .load     (load),
        .step     (step),
        .we       (we)
    );

    burst_addr_ctr #(.IW(IW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_idx (start_idx),
        .step     (step),
        .ptr      (ptr),
        .ptr_nxt  (ptr_nxt)
    );

    burst_mem #(.DW(AW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .be    (~cbe_n[NB-1:0]),
        .waddr (ptr),
        .wdata (ad_in),
        .raddr (ptr_nxt),
        .rdata (ad_out)
    );

endmodule

// File: tb/burst_target_test.sv
module burst_target_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n;

    int checks = 0;
    int errors = 0;

    logic [31:0] ref_mem [16];
    logic [31:0] wdat    [16];
    logic [3:0]  wbe     [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_target uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One frame; outputs compared against the model each cycle.
    task automatic run_frame(input logic [31:0] addr, input logic [3:0] cmd,
                             input int n, input logic [15:0] stall, input string req);
        bit claim, rd, stalled, exp_trdy;
        int ptr, beat, k;
        chk(devsel_n && trdy_n && !ad_oe, {req, "/R9 idle before frame"},
            {29'd0, devsel_n, trdy_n, ad_oe}, 32'd6);
        claim = (cmd == 4'b0110 || cmd == 4'b0111) && addr >= BASE && addr < BASE + 64;
        rd    = (cmd == 4'b0110);
        ptr   = ((addr - BASE) >> 2) % 16;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        beat = 0; k = 0; stalled = 0;
        while (beat < n) begin
            @(negedge clk); k++;
            exp_trdy = claim && !(rd && k == 1);
            chk(devsel_n == !claim, {req, "/R4 devsel_n"}, 32'(devsel_n), 32'(!claim));
            chk(trdy_n == !exp_trdy, {req, "/R5 trdy_n"}, 32'(trdy_n), 32'(!exp_trdy));
            chk(ad_oe == (claim && rd), {req, "/R5 ad_oe"}, 32'(ad_oe), 32'(claim && rd));
            if (exp_trdy && rd)
                chk(ad_out == ref_mem[ptr], {req, "/R5 read data"}, ad_out, ref_mem[ptr]);
            if (stall[beat] && !stalled) begin
                irdy_n = 1'b1; frame_n = 1'b0; stalled = 1;   // R6 stall cycle
            end else begin
                irdy_n  = 1'b0;
                frame_n = (beat == n - 1);
                ad_in   = rd ? 32'h0 : wdat[beat];
                cbe_n   = rd ? 4'h0 : wbe[beat];
                if (exp_trdy || !claim) begin
                    if (claim && !rd)
                        for (int b = 0; b < 4; b++)
                            if (!wbe[beat][b]) ref_mem[ptr][8*b +: 8] = wdat[beat][8*b +: 8];
                    ptr = (ptr + 1) % 16;
                    beat++;
                    stalled = 0;
                end
            end
        end
        @(negedge clk);
        // R9 released right after the final beat
        chk(devsel_n && trdy_n && !ad_oe, {req, "/R9 release"},
            {29'd0, devsel_n, trdy_n, ad_oe}, 32'd6);
        frame_n = 1'b1; irdy_n = 1'b1; ad_in = 32'h0; cbe_n = 4'hF;
        @(negedge clk);
    endtask

    task automatic readback_all(input string req);
        run_frame(BASE, 4'b0110, 16, 16'h0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = 32'h0;
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(devsel_n && trdy_n && !ad_oe, "R1 reset outputs",
            {29'd0, devsel_n, trdy_n, ad_oe}, 32'd6);
        readback_all("R1 memory zero");

        // R4 R7 plain write burst
        for (int i = 0; i < 16; i++) begin
            wdat[i] = 32'h1122_3344 + 32'h0101_0101 * i; wbe[i] = 4'h0;
        end
        run_frame(BASE, 4'b0111, 4, 16'h0, "R4 write burst");
        // R5 R6 read with stalls, including on the final beat
        run_frame(BASE, 4'b0110, 4, 16'b1010, "R6 read stalls");

        // R8 partial byte enables, low address bits ignored (R3)
        wdat[0] = 32'hAABB_CCDD; wbe[0] = 4'b1010;
        wdat[1] = 32'h5566_7788; wbe[1] = 4'b0111;
        run_frame(BASE + 32'h0000_000B, 4'b0111, 2, 16'h0, "R8 byte enables");
        run_frame(BASE + 32'h0000_0008, 4'b0110, 2, 16'h0, "R8 readback");

        // R7 wrap across word 15, write with stalls (R6)
        for (int i = 0; i < 4; i++) begin
            wdat[i] = 32'hC0DE_0000 + i; wbe[i] = 4'h0;
        end
        run_frame(BASE + 32'h38, 4'b0111, 4, 16'b1001, "R7 wrap write");
        run_frame(BASE + 32'h38, 4'b0110, 4, 16'h0, "R7 wrap read");

        // R9 single-word frames back to back
        wdat[0] = 32'hFEED_0001; wbe[0] = 4'h0;
        run_frame(BASE + 32'h14, 4'b0111, 1, 16'h0, "R9 single write");
        run_frame(BASE + 32'h14, 4'b0110, 1, 16'h0, "R9 single read");

        // R2 R10 ignored command codes in window
        for (int i = 0; i < 4; i++) begin
            wdat[i] = 32'hDEAD_BEEF; wbe[i] = 4'h0;
        end
        run_frame(BASE, 4'b0011, 3, 16'h0, "R2 device write ignored");
        run_frame(BASE, 4'b0010, 2, 16'h0, "R2 device read ignored");
        run_frame(BASE, 4'b1111, 2, 16'h0, "R10 other code ignored");
        // R3 outside the window
        run_frame(BASE + 32'h40, 4'b0111, 2, 16'h0, "R3 above window");
        run_frame(BASE - 32'h4,  4'b0111, 2, 16'h0, "R3 below window");
        run_frame(32'h0000_0000, 4'b0110, 1, 16'h0, "R3 read outside");
        readback_all("R10 memory unchanged");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule